// File: doc/BRIEF.md
# Dual-Window Reservoir and Load Switch Controller

This controller keeps two sampled voltages of an energy-harvesting power stage inside their own hysteresis windows by commanding three switches. The first loop watches the high-voltage reservoir. When the reservoir climbs to its upper limit, the controller turns on a bypass switch and steers the shared inductor toward the load capacitor. When the reservoir has fallen to its lower limit, the bypass opens. The steering switch stays toward the load capacitor until the inductor reports that it is empty, and only then returns to its normal position.

The second loop watches the load-capacitor voltage and supplies the load in bursts. The load is connected once the capacitor reaches its upper limit and is disconnected once the capacitor has sagged to its lower limit. The two loops share only the clock, the reset and the sample strobe. Voltages and limits are unsigned codes of a parameterised width, so 20.5 V may be written as code 2050 at 10 mV per step.

Threshold comparisons take effect only on cycles where the sample strobe is high. If a window is programmed with its low limit not below its high limit, that loop falls back to its safe state. Reset is asynchronous, active low, and released synchronously.

Top module: `pwr_window_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no qualifying sample, `load_on`, `bypass_on` and `steer_left` are all 0. Asserting `rst_n` low clears all three outputs at once, without waiting for a clock edge.
- R2: With `bypass_on`=0 and `steer_left`=0, a valid sample with `res_lvl` >= `res_hi` sets both `bypass_on` and `steer_left` to 1 after the next rising clock edge.
- R3: While `bypass_on`=1, a valid sample with `res_lvl` <= `res_lo` clears `bypass_on` after the next edge, and `steer_left` stays 1.
- R4: Once the bypass has opened, `steer_left` returns to 0 only in the cycle after `ind_empty`=1. This applies whether or not `smp_valid` is high, and reservoir samples are ignored in that wait. When `ind_empty` is asserted while the bypass is still on, it has no effect.
- R5: `bypass_on`=1 never occurs while `steer_left`=0.
- R6: With `load_on`=0, a valid sample with `cap_lvl` >= `cap_hi` sets `load_on` after the next edge.
- R7: With `load_on`=1, a valid sample with `cap_lvl` <= `cap_lo` clears `load_on` after the next edge.
- R8: A valid sample lying strictly between a loop's two limits leaves that loop's outputs unchanged.
- R9: While `smp_valid`=0, `load_on` and `bypass_on` keep their values. `steer_left` also keeps its value, except for the return described in R4.
- R10: If `res_lo` >= `res_hi`, then after the next edge `bypass_on`=0 and `steer_left`=0, whatever the strobe. If `cap_lo` >= `cap_hi`, then after the next edge `load_on`=0.
- R11: The loops are independent. Reservoir inputs and limits never change `load_on`, and load-capacitor inputs and limits never change `bypass_on` or `steer_left`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | High on cycles where `res_lvl` and `cap_lvl` carry fresh samples |
| res_lvl | input | VW | Sampled reservoir voltage code (unsigned) |
| cap_lvl | input | VW | Sampled load-capacitor voltage code (unsigned) |
| ind_empty | input | 1 | Inductor has fully discharged |
| res_lo | input | VW | Reservoir lower limit |
| res_hi | input | VW | Reservoir upper limit |
| cap_lo | input | VW | Load-capacitor lower limit |
| cap_hi | input | VW | Load-capacitor upper limit |
| load_on | output | 1 | 1 connects the load to the load capacitor |
| bypass_on | output | 1 | 1 closes the reservoir bypass switch |
| steer_left | output | 1 | 1 routes the inductor to the load capacitor; 0 is the normal position |

## Verification
The bench builds the block with its default parameters: 12-bit codes and a two-stage reset synchroniser. With 12-bit codes, both typical windows can be written directly in 10 mV steps (1950/2050 and 320/360). Samples that land exactly on a limit, and limits set equal to one another, are therefore easy to reach. The two-stage synchroniser keeps the reset release short enough that a mid-run asynchronous reset, followed by recovery, fits in a handful of cycles.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    RES_IDLE  = 2'd0,
    RES_DUMP  = 2'd1,
    RES_DRAIN = 2'd2
  } res_mode_e;

endpackage

// File: rtl/pwc_rst_sync.sv
module pwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwc_win_ok.sv
module pwc_win_ok #(
  parameter int VW = 12
) (
  input  logic [VW-1:0] lo_i,
  input  logic [VW-1:0] hi_i,
  output logic          ok_o
);

  assign ok_o = (lo_i < hi_i);

endmodule

// File: rtl/pwc_res_loop.sv
module pwc_res_loop
  import pwc_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [VW-1:0] lvl_i,
  input  logic [VW-1:0] lo_i,
  input  logic [VW-1:0] hi_i,
  input  logic          win_ok_i,
  input  logic          drained_i,
  output logic          bypass_o,
  output logic          steer_left_o
);

  res_mode_e mode_q, mode_d;
  logic      bypass_q, bypass_d;
  logic      left_q, left_d;
  logic      upd_en;
  logic      rst_n;

  assign rst_n = arst_ni & rst_ni;

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    if (!win_ok_i) begin
      mode_d = RES_IDLE;
    end else begin
      unique case (mode_q)
        RES_IDLE:  if (smp_vld_i && (lvl_i >= hi_i)) mode_d = RES_DUMP;
        RES_DUMP:  if (smp_vld_i && (lvl_i <= lo_i)) mode_d = RES_DRAIN;
        RES_DRAIN: if (drained_i)                    mode_d = RES_IDLE;
        default:                                     mode_d = RES_IDLE;
      endcase
    end
    bypass_d = (mode_d == RES_DUMP);
    left_d   = (mode_d != RES_IDLE);
    upd_en   = (mode_d != mode_q);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RES_IDLE;
      bypass_q <= 1'b0;
      left_q   <= 1'b0;
    end else if (upd_en) begin
      mode_q   <= mode_d;
      bypass_q <= bypass_d;
      left_q   <= left_d;
    end
  end

  assign bypass_o     = bypass_q;
  assign steer_left_o = left_q;

  assert_bypass_needs_left_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    bypass_o |-> steer_left_o);

  assert_dump_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bypass_o && !steer_left_o && win_ok_i && smp_vld_i && (lvl_i >= hi_i))
      |=> (bypass_o && steer_left_o));

  assert_dump_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bypass_o && win_ok_i && smp_vld_i && (lvl_i <= lo_i))
      |=> (!bypass_o && steer_left_o));

  assert_left_waits_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (steer_left_o && !bypass_o && win_ok_i && !drained_i) |=> steer_left_o);

  assert_hold_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!smp_vld_i && win_ok_i && !drained_i) |=> $stable({bypass_o, steer_left_o}));

  assert_safe_reservoir_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !win_ok_i |=> (!bypass_o && !steer_left_o));

endmodule

// File: rtl/pwc_load_loop.sv
module pwc_load_loop #(
  parameter int VW = 12
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [VW-1:0] lvl_i,
  input  logic [VW-1:0] lo_i,
  input  logic [VW-1:0] hi_i,
  input  logic          win_ok_i,
  output logic          load_on_o
);

  logic on_q, on_d;
  logic upd_en;
  logic rst_n;

  assign rst_n = arst_ni & rst_ni;

  always_comb begin
    on_d = on_q;
    if (!win_ok_i) begin
      on_d = 1'b0;
    end else if (smp_vld_i) begin
      if (!on_q && (lvl_i >= hi_i)) on_d = 1'b1;
      if (on_q && (lvl_i <= lo_i))  on_d = 1'b0;
    end
    upd_en = (on_d != on_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
    end else if (upd_en) begin
      on_q <= on_d;
    end
  end

  assign load_on_o = on_q;

  assert_connect_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!load_on_o && win_ok_i && smp_vld_i && (lvl_i >= hi_i)) |=> load_on_o);

  assert_disconnect_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_on_o && smp_vld_i && (lvl_i <= lo_i)) |=> !load_on_o);

  assert_load_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!smp_vld_i && win_ok_i) |=> $stable(load_on_o));

  assert_safe_load_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !win_ok_i |=> !load_on_o);

endmodule

// File: rtl/pwr_window_ctrl.sv
module pwr_window_ctrl #(
  parameter int VW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [VW-1:0] res_lvl,
  input  logic [VW-1:0] cap_lvl,
  input  logic          ind_empty,
  input  logic [VW-1:0] res_lo,
  input  logic [VW-1:0] res_hi,
  input  logic [VW-1:0] cap_lo,
  input  logic [VW-1:0] cap_hi,
  output logic          load_on,
  output logic          bypass_on,
  output logic          steer_left
);

  logic rst_sync_n;
  logic res_win_ok;
  logic cap_win_ok;

  pwc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  pwc_win_ok #(.VW(VW)) u_res_win (
    .lo_i (res_lo),
    .hi_i (res_hi),
    .ok_o (res_win_ok)
  );

  pwc_win_ok #(.VW(VW)) u_cap_win (
    .lo_i (cap_lo),
    .hi_i (cap_hi),
    .ok_o (cap_win_ok)
  );

  pwc_res_loop #(.VW(VW)) u_res_loop (
    .clk_i        (clk),
    .arst_ni      (rst_n),
    .rst_ni       (rst_sync_n),
    .smp_vld_i    (smp_valid),
    .lvl_i        (res_lvl),
    .lo_i         (res_lo),
    .hi_i         (res_hi),
    .win_ok_i     (res_win_ok),
    .drained_i    (ind_empty),
    .bypass_o     (bypass_on),
    .steer_left_o (steer_left)
  );

  pwc_load_loop #(.VW(VW)) u_load_loop (
    .clk_i     (clk),
    .arst_ni   (rst_n),
    .rst_ni    (rst_sync_n),
    .smp_vld_i (smp_valid),
    .lvl_i     (cap_lvl),
    .lo_i      (cap_lo),
    .hi_i      (cap_hi),
    .win_ok_i  (cap_win_ok),
    .load_on_o (load_on)
  );

endmodule

// File: tb/pwr_window_ctrl_tb_top.sv
module pwr_window_ctrl_tb_top;

  localparam int VW = 12;
  localparam int NV = 12;
  localparam int VBITS = 2*VW + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [VW-1:0] res_lvl, cap_lvl, res_lo, res_hi, cap_lo, cap_hi;
  logic          ind_empty;
  logic          load_on, bypass_on, steer_left;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwr_window_ctrl #(.VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .res_lvl(res_lvl), .cap_lvl(cap_lvl), .ind_empty(ind_empty),
    .res_lo(res_lo), .res_hi(res_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .load_on(load_on), .bypass_on(bypass_on), .steer_left(steer_left)
  );

  // {res, cap, valid, empty, exp_bypass, exp_left, exp_load}
  localparam logic [VBITS-1:0] VEC [NV] = '{
    {12'd2000, 12'd340, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 inside both
    {12'd2050, 12'd340, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R9 no strobe
    {12'd2050, 12'd340, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 at upper limit
    {12'd2000, 12'd360, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R4 empty ignored, R6
    {12'd1950, 12'd340, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R9
    {12'd1950, 12'd340, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R3, R8 load holds
    {12'd2100, 12'd320, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 waits, R7
    {12'd2100, 12'd330, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 empty w/o strobe
    {12'd2000, 12'd350, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R8
    {12'd2060, 12'd310, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R2
    {12'd1900, 12'd370, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R3, R6
    {12'd1900, 12'd340, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}   // R4 return
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic eb, input logic el, input logic eld);
    chk(req, "bypass_on", bypass_on, eb);
    chk(req, "steer_left", steer_left, el);
    chk(req, "load_on", load_on, eld);
  endtask

  task automatic step(input logic [VW-1:0] r, input logic [VW-1:0] c,
                      input logic v, input logic e);
    @(negedge clk);
    res_lvl = r; cap_lvl = c; smp_valid = v; ind_empty = e;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; ind_empty = 1'b0;
    res_lvl = '0; cap_lvl = '0;
    res_lo = 12'd1950; res_hi = 12'd2050; cap_lo = 12'd320; cap_hi = 12'd360;
    repeat (3) @(negedge clk);
    chk3("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk3("R1 after release", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VBITS-1:0] v;
      v = VEC[i];
      step(v[28:17], v[16:5], v[4], v[3]);
      chk3($sformatf("vector %0d", i), v[2], v[1], v[0]);
    end

    // R11: reservoir activity leaves the connected load alone
    step(12'd2080, 12'd340, 1'b1, 1'b0);
    chk3("R11 dump with load on", 1'b1, 1'b1, 1'b1);
    // R10: reservoir window collapsed, forced safe without strobe
    res_lo = 12'd2000; res_hi = 12'd2000;
    step(12'd2080, 12'd340, 1'b0, 1'b0);
    chk3("R10 res window invalid", 1'b0, 1'b0, 1'b1);
    // R11: load loop keeps working while reservoir loop is parked
    step(12'd2100, 12'd300, 1'b1, 1'b0);
    chk3("R11 load off, R10 bypass held off", 1'b0, 1'b0, 1'b0);
    step(12'd2100, 12'd370, 1'b1, 1'b0);
    chk3("R11 load on, R10 bypass held off", 1'b0, 1'b0, 1'b1);
    // R10: load window inverted
    cap_lo = 12'd400; cap_hi = 12'd360;
    step(12'd2000, 12'd370, 1'b0, 1'b0);
    chk("R10 load window invalid", "load_on", load_on, 1'b0);
    step(12'd2000, 12'd500, 1'b1, 1'b0);
    chk("R10 load held off", "load_on", load_on, 1'b0);

    // R1: asynchronous reset mid-run
    res_lo = 12'd1950; res_hi = 12'd2050; cap_lo = 12'd320; cap_hi = 12'd360;
    step(12'd2100, 12'd370, 1'b1, 1'b0);
    chk3("R2/R6 before async reset", 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    smp_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk3("R1 async clear", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk3("R1 after second release", 1'b0, 1'b0, 1'b0);

    finish_run();
  end

endmodule